// File: doc/BRIEF.md
# Unsigned Saturating Integer Execution Unit

This execution unit takes one 32-bit X-form instruction word together with the two source operand values, already read from the register file, and returns the clamped arithmetic result one clock later. It supports five operations. Unsigned addition is available at word, halfword and byte width, and unsigned subtraction at halfword and byte width. An addition that overflows its width pins the result to the all-ones value of that width. A subtraction that would go below zero pins the result to zero. A subtraction takes the second source operand as the minuend and the first source operand as the subtrahend.

The unit has no register file, no condition-code update and no hazard logic. A caller presents `in_valid` with the instruction and operands. On the next cycle the caller receives either a valid result with its destination index, or an illegal-instruction indication. A small output state machine sets what is presented. In `ST_IDLE` nothing is presented. In `ST_RESULT` a legal operation completed. In `ST_TRAP` an undecodable word was received. Every cycle the machine moves to `ST_RESULT` on a legal request, to `ST_TRAP` on an illegal one, and back to `ST_IDLE` when `in_valid` is low.

Top module: `usat_exec_unit`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `out_valid`, `out_illegal` and `out_sat` are 0 and `out_result` is 0.
- R2: A request taken with `in_valid` high at a clock edge is presented on the outputs after exactly that edge and is held for one cycle. Back-to-back requests give back-to-back outputs. A cycle with `in_valid` low leaves `out_valid` and `out_illegal` low on the following cycle.
- R3: Fields are numbered with bit 31 as the most significant bit. The primary opcode is `instr[31:26]` and must be 31. The destination index is `instr[25:21]` and appears on `out_rd`. The extended opcode is `instr[10:1]`. `instr[0]` and the register-index fields `instr[20:11]` have no effect on the result.
- R4: Extended opcode 0x36A adds `src_a + src_b` at 32 bits. If the sum exceeds 0xFFFFFFFF, the result is 0xFFFFFFFF.
- R5: Extended opcode 0x3AA adds the low 16 bits of each operand and zero-extends the sum to 32 bits. If the sum exceeds 0xFFFF, the result is 0xFFFF.
- R6: Extended opcode 0x3EA adds the low 8 bits of each operand and zero-extends the sum. If the sum exceeds 0xFF, the result is 0xFF.
- R7: Extended opcode 0x3A8 computes `src_b[15:0] - src_a[15:0]` and zero-extends the difference. If `src_a[15:0] > src_b[15:0]`, the result is 0.
- R8: Extended opcode 0x3E8 computes `src_b[7:0] - src_a[7:0]` and zero-extends the difference. If `src_a[7:0] > src_b[7:0]`, the result is 0.
- R9: Any other extended opcode, including the would-be word subtract 0x368, and any primary opcode other than 31, raises `out_illegal` with `out_valid` low, `out_result` 0 and `out_sat` 0.
- R10: `out_sat` is 1 exactly when clamping replaced the true result. A sum that lands exactly on the maximum, or a difference of exactly zero, leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe for the current cycle |
| instr | input | 32 | X-form instruction word |
| src_a | input | 32 | First source operand value |
| src_b | input | 32 | Second source operand value |
| out_valid | output | 1 | Legal result presented |
| out_illegal | output | 1 | Request was not a supported instruction |
| out_rd | output | 5 | Destination register index of the result |
| out_result | output | 32 | Clamped, zero-extended result |
| out_sat | output | 1 | Clamping changed the result |

## Verification
The bench targets operand order in the subtract cases. A 0x0028/0x002D pair gives 5 only when the second source is the minuend, and a swapped design returns a clamped 0. It also targets the upper operand bits in narrow operations, which a design that fails to mask them turns into a false overflow or a non-zero upper half. The edges of the saturation flag are covered: a sum exactly at the maximum and a difference of exactly zero must leave the flag clear, so an off-by-one comparison raises it wrongly. Illegal encodings close the set. The extended opcode of the missing word subtract and a wrong primary opcode must both trap, and a loose decoder would return a value for them instead.

// File: rtl/usat_pkg.sv
package usat_pkg;
    localparam int XLEN    = 32;
    localparam int REG_IDX = 5;
    localparam int XO_W    = 10;

    localparam logic [5:0]      PRIMARY_X = 6'd31;
    localparam logic [XO_W-1:0] XO_ADDW   = 10'h36A;
    localparam logic [XO_W-1:0] XO_ADDH   = 10'h3AA;
    localparam logic [XO_W-1:0] XO_ADDB   = 10'h3EA;
    localparam logic [XO_W-1:0] XO_SUBH   = 10'h3A8;
    localparam logic [XO_W-1:0] XO_SUBB   = 10'h3E8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADD_W,
        OP_ADD_H,
        OP_ADD_B,
        OP_SUB_H,
        OP_SUB_B
    } sat_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESULT,
        ST_TRAP
    } out_state_e;

    typedef struct packed {
        logic                legal;
        sat_op_e             op;
        logic [REG_IDX-1:0]  rd;
    } dec_t;
endpackage

// File: rtl/usat_decode.sv
module usat_decode
    import usat_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [5:0]      prim;
    logic [XO_W-1:0] xo;
    logic            unused_fields;

    assign prim          = instr[31:26];
    assign xo            = instr[10:1];
    assign unused_fields = ^{instr[20:11], instr[0]};

    always_comb begin
        dec.rd    = instr[25:21];
        dec.op    = OP_NONE;
        dec.legal = 1'b0;
        if (prim == PRIMARY_X) begin
            unique case (xo)
                XO_ADDW: dec.op = OP_ADD_W;
                XO_ADDH: dec.op = OP_ADD_H;
                XO_ADDB: dec.op = OP_ADD_B;
                XO_SUBH: dec.op = OP_SUB_H;
                XO_SUBB: dec.op = OP_SUB_B;
                default: dec.op = OP_NONE;
            endcase
        end
        dec.legal = (dec.op != OP_NONE);
    end
endmodule

// File: rtl/usat_alu.sv
module usat_alu
    import usat_pkg::*;
#(
    parameter int W = XLEN
) (
    input  sat_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         sat
);
    localparam int HW = W / 2;
    localparam int BW = W / 4;

    logic [W:0]  sum_w;
    logic [HW:0] sum_h;
    logic [BW:0] sum_b;
    logic [HW:0] dif_h;
    logic [BW:0] dif_b;

    assign sum_w = {1'b0, a} + {1'b0, b};
    assign sum_h = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]};
    assign sum_b = {1'b0, a[BW-1:0]} + {1'b0, b[BW-1:0]};
    assign dif_h = {1'b0, b[HW-1:0]} - {1'b0, a[HW-1:0]};
    assign dif_b = {1'b0, b[BW-1:0]} - {1'b0, a[BW-1:0]};

    always_comb begin
        res = '0;
        sat = 1'b0;
        unique case (op)
            OP_ADD_W: begin
                sat = sum_w[W];
                res = sat ? '1 : sum_w[W-1:0];
            end
            OP_ADD_H: begin
                sat = sum_h[HW];
                res = {{(W-HW){1'b0}}, (sat ? {HW{1'b1}} : sum_h[HW-1:0])};
            end
            OP_ADD_B: begin
                sat = sum_b[BW];
                res = {{(W-BW){1'b0}}, (sat ? {BW{1'b1}} : sum_b[BW-1:0])};
            end
            OP_SUB_H: begin
                sat = dif_h[HW];
                res = {{(W-HW){1'b0}}, (sat ? {HW{1'b0}} : dif_h[HW-1:0])};
            end
            OP_SUB_B: begin
                sat = dif_b[BW];
                res = {{(W-BW){1'b0}}, (sat ? {BW{1'b0}} : dif_b[BW-1:0])};
            end
            default: begin
                res = '0;
                sat = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/usat_exec_unit.sv
module usat_exec_unit
    import usat_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic [W-1:0]       src_a,
    input  logic [W-1:0]       src_b,
    output logic               out_valid,
    output logic               out_illegal,
    output logic [REG_IDX-1:0] out_rd,
    output logic [W-1:0]       out_result,
    output logic               out_sat
);
    dec_t               dec;
    logic [W-1:0]       alu_res;
    logic               alu_sat;
    out_state_e         state_q, state_d;
    logic [W-1:0]       res_q;
    logic               sat_q;
    logic [REG_IDX-1:0] rd_q;

    usat_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    usat_alu #(.W(W)) u_alu (
        .op  (dec.op),
        .a   (src_a),
        .b   (src_b),
        .res (alu_res),
        .sat (alu_sat)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (in_valid) begin
            state_d = dec.legal ? ST_RESULT : ST_TRAP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
            sat_q   <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid && dec.legal) begin
                res_q <= alu_res;
                sat_q <= alu_sat;
                rd_q  <= dec.rd;
            end else begin
                res_q <= '0;
                sat_q <= 1'b0;
                rd_q  <= in_valid ? dec.rd : '0;
            end
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_illegal = 1'b0;
        out_result  = '0;
        out_sat     = 1'b0;
        out_rd      = rd_q;
        unique case (state_q)
            ST_IDLE: begin
                out_valid   = 1'b0;
                out_illegal = 1'b0;
            end
            ST_RESULT: begin
                out_valid  = 1'b1;
                out_result = res_q;
                out_sat    = sat_q;
            end
            ST_TRAP: begin
                out_illegal = 1'b1;
            end
            default: begin
                out_valid   = 1'b0;
                out_illegal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/usat_exec_chk.sv
module usat_exec_chk
    import usat_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [31:0]        instr,
    input logic               out_valid,
    input logic               out_illegal,
    input logic [REG_IDX-1:0] out_rd,
    input logic [31:0]        out_result,
    input logic               out_sat
);
    AST_ANSWER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid ^ out_illegal)); // R2
    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_valid || out_illegal)); // R2
    AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_valid || out_rd == $past(instr[25:21]))); // R3
    AST_BAD_PRIMARY_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] != 6'd31) |=> out_illegal); // R9
    AST_TRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == 32'h0 && !out_sat && !out_valid)); // R9
    AST_SAT_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat |-> (out_result == 32'h0 || out_result == 32'hFF ||
                     out_result == 32'hFFFF || out_result == 32'hFFFF_FFFF)); // R10
    AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'd31 &&
         (instr[10:1] == 10'h3AA || instr[10:1] == 10'h3A8))
        |=> (out_result[31:16] == 16'h0)); // R5
    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'd31 &&
         (instr[10:1] == 10'h3EA || instr[10:1] == 10'h3E8))
        |=> (out_result[31:8] == 24'h0)); // R6
endmodule

bind usat_exec_unit usat_exec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .instr       (instr),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_rd      (out_rd),
    .out_result  (out_result),
    .out_sat     (out_sat)
);

// File: tb/sim_usat_exec_unit.sv
module sim_usat_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] src_a = 32'h0;
    logic [31:0] src_b = 32'h0;
    logic        out_valid, out_illegal, out_sat;
    logic [4:0]  out_rd;
    logic [31:0] out_result;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usat_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_rd(out_rd),
        .out_result(out_result), .out_sat(out_sat)
    );

    function automatic logic [31:0] mk(input logic [5:0] prim, input logic [4:0] rd,
                                       input logic [9:0] xo);
        return {prim, rd, 5'd7, 5'd9, xo, 1'b0};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // one request, then check the outputs one cycle later
    task automatic run(input string req, input logic [31:0] iw,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic ev, input logic ei, input logic [4:0] erd,
                       input logic [31:0] eres, input logic esat);
        @(negedge clk);
        in_valid = 1'b1; instr = iw; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "valid", {31'h0, out_valid}, {31'h0, ev});
        chk(req, "illegal", {31'h0, out_illegal}, {31'h0, ei});
        if (ev) chk(req, "rd", {27'h0, out_rd}, {27'h0, erd});
        chk(req, "result", out_result, eres);
        chk(req, "sat", {31'h0, out_sat}, {31'h0, esat});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", {31'h0, out_valid}, 32'h0);
        chk("R1", "illegal in reset", {31'h0, out_illegal}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "result after reset", out_result, 32'h0);
        chk("R1", "sat after reset", {31'h0, out_sat}, 32'h0);
    endtask

    task automatic t_word_add;
        run("R4", mk(6'd31, 5'd3, 10'h36A), 32'hFFFF_FFFF, 32'h1, 1, 0, 5'd3, 32'hFFFF_FFFF, 1);
        run("R4", mk(6'd31, 5'd4, 10'h36A), 32'h1234_5678, 32'h1111_1111, 1, 0, 5'd4, 32'h2345_6789, 0);
        run("R4", mk(6'd31, 5'd5, 10'h36A), 32'h8000_0000, 32'h8000_0000, 1, 0, 5'd5, 32'hFFFF_FFFF, 1);
        run("R10", mk(6'd31, 5'd6, 10'h36A), 32'hFFFF_FFFE, 32'h1, 1, 0, 5'd6, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_half_add;
        run("R5", mk(6'd31, 5'd1, 10'h3AA), 32'h1234_FFF0, 32'hABCD_0005, 1, 0, 5'd1, 32'h0000_FFF5, 0);
        run("R5", mk(6'd31, 5'd2, 10'h3AA), 32'h0000_8000, 32'h0000_8000, 1, 0, 5'd2, 32'h0000_FFFF, 1);
    endtask

    task automatic t_byte_add;
        run("R6", mk(6'd31, 5'd8, 10'h3EA), 32'h0000_00FF, 32'h1, 1, 0, 5'd8, 32'h0000_00FF, 1);
        run("R6", mk(6'd31, 5'd9, 10'h3EA), 32'h7770_0010, 32'h0000_00EF, 1, 0, 5'd9, 32'h0000_00FF, 0);
    endtask

    task automatic t_half_sub;
        run("R7", mk(6'd31, 5'd10, 10'h3A8), 32'h0028, 32'h002D, 1, 0, 5'd10, 32'h0005, 0);
        run("R7", mk(6'd31, 5'd11, 10'h3A8), 32'h002D, 32'h0028, 1, 0, 5'd11, 32'h0000, 1);
        run("R10", mk(6'd31, 5'd12, 10'h3A8), 32'h0040, 32'h0040, 1, 0, 5'd12, 32'h0000, 0);
        run("R7", mk(6'd31, 5'd13, 10'h3A8), 32'hFFFF_0001, 32'h0000_1000, 1, 0, 5'd13, 32'h0000_0FFF, 0);
    endtask

    task automatic t_byte_sub;
        run("R8", mk(6'd31, 5'd14, 10'h3E8), 32'h04, 32'h10, 1, 0, 5'd14, 32'h0C, 0);
        run("R8", mk(6'd31, 5'd15, 10'h3E8), 32'h05, 32'h04, 1, 0, 5'd15, 32'h00, 1);
        run("R8", mk(6'd31, 5'd16, 10'h3E8), 32'h100, 32'h203, 1, 0, 5'd16, 32'h03, 0);
    endtask

    task automatic t_illegal;
        run("R9", mk(6'd31, 5'd3, 10'h368), 32'h5, 32'h9, 0, 1, 5'd0, 32'h0, 0);
        run("R9", mk(6'd30, 5'd3, 10'h36A), 32'hFFFF_FFFF, 32'h1, 0, 1, 5'd0, 32'h0, 0);
        run("R9", mk(6'd31, 5'd3, 10'h000), 32'h1, 32'h1, 0, 1, 5'd0, 32'h0, 0);
    endtask

    task automatic t_decode;
        run("R3", 32'h7C67_1ED4, 32'hFFFF_FFFF, 32'h1, 1, 0, 5'd3, 32'hFFFF_FFFF, 1);
        run("R3", 32'h7C67_1ED5, 32'h10, 32'h20, 1, 0, 5'd3, 32'h30, 0);
        run("R3", mk(6'd31, 5'd31, 10'h3EA) | 32'h001F_F800, 32'h01, 32'h02, 1, 0, 5'd31, 32'h03, 0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        in_valid = 1'b1; instr = mk(6'd31, 5'd20, 10'h3EA); src_a = 32'h10; src_b = 32'h20;
        @(negedge clk);
        chk("R2", "first of pair", out_result, 32'h30);
        instr = mk(6'd31, 5'd21, 10'h3A8); src_a = 32'h1; src_b = 32'h3;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "second of pair", out_result, 32'h2);
        chk("R2", "second rd", {27'h0, out_rd}, 32'd21);
        @(negedge clk);
        chk("R2", "idle valid", {31'h0, out_valid}, 32'h0);
        chk("R2", "idle illegal", {31'h0, out_illegal}, 32'h0);
    endtask

    initial begin
        t_reset;
        t_word_add;
        t_half_add;
        t_byte_add;
        t_half_sub;
        t_byte_sub;
        t_illegal;
        t_decode;
        t_latency;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule